// File: doc/BRIEF.md
# Boundary-Scan Self-Test Engine

This block holds the forty data boundary cells of a 20-bit bidirectional scan-test transceiver (twenty on the A side, twenty on the B side). It steps those cells through one built-in test algorithm per test clock. An algorithm runs only while a run-test instruction is loaded, the test controller is parked in Run-Test/Idle, and exactly one data direction is enabled. A 3-bit opcode picks the algorithm. Two modes are 40-bit: a pattern generator, and a signature compressor over all forty pins. Two modes are 20-bit and combined: the input side compresses a signature while the output side either generates patterns or counts up. The last mode samples the input pins and inverts the output cells on every edge.

The direction enables decide which side is input and which is output. Output values reach the pins through a bank of shadow latches that is updated on the falling test-clock edge. The twelve control cells are owned by the surrounding scan chain and are only read here: two of them gate the pin drivers. A parallel load port stands in for the serial scan path so that cells can be seeded. The engine advances on every rising edge with no back-pressure, so all pins are plain control and data signals and none use valid/ready.

Top module: `bst_engine`

## Requirements
- R1: While rst_n is low, cell_shift, a_drive and b_drive are all zero.
- R2: When runtest_on or rti_state is low, and load_en is low, cell_shift holds its value across the rising edge.
- R3: When en_ab equals en_ba, and load_en is low, cell_shift holds its value (bypass behaviour).
- R4: load_en high writes load_cells into cell_shift on that rising edge, whatever the mode. The following falling edge copies all forty cells to a_drive (bits 19:0) and b_drive (bits 39:20).
- R5: In opcode x00, the input-side cells take the input pins and the output-side cells are inverted on each rising edge.
- R6: After a toggle step, the following falling edge copies only the output-side cells to that side's drive pins. The algorithms other than toggle never change a_drive or b_drive.
- R7: In opcode x01, the combined register C = {output cells, input cells} steps as C' = {C[38:0], C[39]^C[37]^C[20]^C[18]}.
- R8: In opcode x10, C' = {C[38:0], C[39]^C[37]^C[20]^C[18]} ^ {output pins, input pins}.
- R9: In opcode 011, input cells I' = {I[18:0], I[19]^I[16]} ^ input pins, and output cells O' = {O[18:0], O[19]^O[16]}.
- R10: In opcode 111, the input cells compress as in R9 and the output cells count up by one, wrapping from all ones to zero.
- R11: With en_ab=1 and en_ba=0, A is the input side (cells 19:0) and B is the output side (cells 39:20). With en_ab=0 and en_ba=1, the sides swap.
- R12: a_oe follows ctl_cells[10] and b_oe follows ctl_cells[11]. The control cells take no part in any algorithm.
- R13: Opcode bit 2 has no effect for low bits 00, 01 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rti_state | input | 1 | Controller is in Run-Test/Idle |
| runtest_on | input | 1 | Run-test instruction is active |
| opcode | input | 3 | Algorithm select |
| en_ab | input | 1 | A-to-B direction enable |
| en_ba | input | 1 | B-to-A direction enable |
| a_pins | input | 20 | Sampled A pin values |
| b_pins | input | 20 | Sampled B pin values |
| ctl_cells | input | 12 | Control boundary cells, read only |
| load_en | input | 1 | Parallel seed of the data cells |
| load_cells | input | 40 | Seed value |
| cell_shift | output | 40 | Data shift cells, A in 19:0 |
| a_drive | output | 20 | Shadow value driven to A pins |
| b_drive | output | 20 | Shadow value driven to B pins |
| a_oe | output | 1 | A driver enable |
| b_oe | output | 1 | B driver enable |

## Verification
The bench seeds the count mode at all ones so that the wrap to zero is checked. A counter that saturated or carried into the input half would fail here. Both direction settings are exercised in every mode. A design that fixed A as the input side would compress the wrong pins, and it would also write shadow latches on the wrong side after a toggle. The bench also sweeps equal enables, an idle controller, and opcode bit 2 against a reference model. A design that ignored the direction rule, or decoded bit 2 in every mode, would then diverge in cell_shift on the first affected edge.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic [2:0] {
    M_TOGGLE   = 3'd0,
    M_PRPG     = 3'd1,
    M_PSA      = 3'd2,
    M_PSA_PRPG = 3'd3,
    M_PSA_CNT  = 3'd4,
    M_HOLD     = 3'd5
  } mode_e;
endpackage

// File: rtl/bst_opdecode.sv
module bst_opdecode
  import bst_pkg::*;
(
  input  logic [2:0] opcode,
  input  logic       rti_state,
  input  logic       runtest_on,
  input  logic       en_ab,
  input  logic       en_ba,
  output mode_e      mode,
  output logic       active
);
  // Algorithms run only with one direction enabled inside run-test idle.
  assign active = rti_state & runtest_on & (en_ab ^ en_ba);

  always_comb begin
    if (!active) begin
      mode = M_HOLD;
    end else begin
      unique case (opcode[1:0])
        2'b00:   mode = M_TOGGLE;
        2'b01:   mode = M_PRPG;
        2'b10:   mode = M_PSA;
        default: mode = opcode[2] ? M_PSA_CNT : M_PSA_PRPG;
      endcase
    end
  end
endmodule

// File: rtl/bst_lane_order.sv
// Swaps the two halves of a 2*W vector unless keep is set.
// Swapping is its own inverse, so one module maps both ways.
module bst_lane_order #(
  parameter int W = 20
) (
  input  logic           keep,
  input  logic [2*W-1:0] x,
  output logic [2*W-1:0] y
);
  localparam int DW = 2 * W;
  for (genvar i = 0; i < DW; i++) begin : g_bit
    localparam int J = (i + W) % DW;
    assign y[i] = keep ? x[i] : x[J];
  end
endmodule

// File: rtl/bst_step.sv
// Next value of the combined view {output half, input half}.
module bst_step
  import bst_pkg::*;
#(
  parameter int W    = 20,
  parameter int WT_A = 40,
  parameter int WT_B = 38,
  parameter int WT_C = 21,
  parameter int WT_D = 19,
  parameter int NT_A = 20,
  parameter int NT_B = 17
) (
  input  mode_e          mode,
  input  logic [2*W-1:0] cur,
  input  logic [2*W-1:0] pin,
  output logic [2*W-1:0] nxt
);
  localparam int DW = 2 * W;

  logic [W-1:0] in_c, out_c, in_p;
  logic         wide_fb, in_fb, out_fb;
  logic [W-1:0] in_misr, out_prpg, out_cnt;
  logic [DW-1:0] wide_shift;

  assign in_c  = cur[W-1:0];
  assign out_c = cur[DW-1:W];
  assign in_p  = pin[W-1:0];

  assign wide_fb = cur[WT_A-1] ^ cur[WT_B-1] ^ cur[WT_C-1] ^ cur[WT_D-1];
  assign in_fb   = in_c[NT_A-1] ^ in_c[NT_B-1];
  assign out_fb  = out_c[NT_A-1] ^ out_c[NT_B-1];

  assign wide_shift = {cur[DW-2:0], wide_fb};
  assign in_misr    = {in_c[W-2:0], in_fb} ^ in_p;
  assign out_prpg   = {out_c[W-2:0], out_fb};
  assign out_cnt    = out_c + {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (mode)
      M_TOGGLE:   nxt = {~out_c, in_p};
      M_PRPG:     nxt = wide_shift;
      M_PSA:      nxt = wide_shift ^ pin;
      M_PSA_PRPG: nxt = {out_prpg, in_misr};
      M_PSA_CNT:  nxt = {out_cnt, in_misr};
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/bst_shadow.sv
// Falling-edge shadow latches, one enable per pin side.
module bst_shadow #(
  parameter int W = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_lo,
  input  logic           upd_hi,
  input  logic [2*W-1:0] src,
  output logic [2*W-1:0] shadow
);
  localparam int DW = 2 * W;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else begin
      if (upd_lo) shadow[W-1:0]  <= src[W-1:0];
      if (upd_hi) shadow[DW-1:W] <= src[DW-1:W];
    end
  end
endmodule

// File: rtl/bst_engine.sv
module bst_engine
  import bst_pkg::*;
#(
  parameter int LANE_W   = 20,
  parameter int CTL_W    = 12,
  parameter int OE_A_IDX = 10,
  parameter int OE_B_IDX = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rti_state,
  input  logic                runtest_on,
  input  logic [2:0]          opcode,
  input  logic                en_ab,
  input  logic                en_ba,
  input  logic [LANE_W-1:0]   a_pins,
  input  logic [LANE_W-1:0]   b_pins,
  input  logic [CTL_W-1:0]    ctl_cells,
  input  logic                load_en,
  input  logic [2*LANE_W-1:0] load_cells,
  output logic [2*LANE_W-1:0] cell_shift,
  output logic [LANE_W-1:0]   a_drive,
  output logic [LANE_W-1:0]   b_drive,
  output logic                a_oe,
  output logic                b_oe
);
  localparam int DW = 2 * LANE_W;

  mode_e          mode;
  logic           active;
  logic [DW-1:0]  shift_q, view_cur, view_pin, view_nxt, phys_nxt;
  logic           upd_lo_q, upd_hi_q;
  logic [DW-1:0]  shadow;
  logic           toggling;

  bst_opdecode u_dec (
    .opcode(opcode), .rti_state(rti_state), .runtest_on(runtest_on),
    .en_ab(en_ab), .en_ba(en_ba), .mode(mode), .active(active)
  );

  // A-side cells sit in the low half; en_ab keeps that as the input half.
  bst_lane_order #(.W(LANE_W)) u_view_cells (
    .keep(en_ab), .x(shift_q), .y(view_cur)
  );
  bst_lane_order #(.W(LANE_W)) u_view_pins (
    .keep(en_ab), .x({b_pins, a_pins}), .y(view_pin)
  );

  bst_step #(.W(LANE_W)) u_step (
    .mode(mode), .cur(view_cur), .pin(view_pin), .nxt(view_nxt)
  );

  bst_lane_order #(.W(LANE_W)) u_unview (
    .keep(en_ab), .x(view_nxt), .y(phys_nxt)
  );

  assign toggling = (mode == M_TOGGLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      upd_lo_q <= 1'b0;
      upd_hi_q <= 1'b0;
    end else begin
      if (load_en)     shift_q <= load_cells;
      else if (active) shift_q <= phys_nxt;
      // Output side is B (high half) when en_ab is set.
      upd_hi_q <= load_en | (!load_en & toggling & en_ab);
      upd_lo_q <= load_en | (!load_en & toggling & en_ba);
    end
  end

  bst_shadow #(.W(LANE_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .upd_lo(upd_lo_q), .upd_hi(upd_hi_q),
    .src(shift_q), .shadow(shadow)
  );

  assign cell_shift = shift_q;
  assign a_drive    = shadow[LANE_W-1:0];
  assign b_drive    = shadow[DW-1:LANE_W];
  assign a_oe       = ctl_cells[OE_A_IDX];
  assign b_oe       = ctl_cells[OE_B_IDX];
endmodule

// File: rtl/bst_engine_chk.sv
module bst_engine_chk #(
  parameter int LANE_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rti_state,
  input logic                runtest_on,
  input logic [2:0]          opcode,
  input logic                en_ab,
  input logic                en_ba,
  input logic [LANE_W-1:0]   a_pins,
  input logic                load_en,
  input logic [2*LANE_W-1:0] load_cells,
  input logic [2*LANE_W-1:0] cell_shift
);
  localparam int DW = 2 * LANE_W;
  logic go_ab;
  assign go_ab = rti_state & runtest_on & en_ab & !en_ba & !load_en;

  // R2
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !(rti_state && runtest_on)) |=> $stable(cell_shift));

  // R3
  a_r3_bypass_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && (en_ab == en_ba)) |=> $stable(cell_shift));

  // R4
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cell_shift == $past(load_cells)));

  // R5
  a_r5_toggle_out: assert property (@(posedge clk) disable iff (!rst_n)
    (go_ab && opcode[1:0] == 2'b00) |=>
      (cell_shift[DW-1:LANE_W] == ~$past(cell_shift[DW-1:LANE_W])));

  // R5
  a_r5_sample_in: assert property (@(posedge clk) disable iff (!rst_n)
    (go_ab && opcode[1:0] == 2'b00) |=>
      (cell_shift[LANE_W-1:0] == $past(a_pins)));

  // R10
  a_r10_count: assert property (@(posedge clk) disable iff (!rst_n)
    (go_ab && opcode == 3'b111) |=>
      (cell_shift[DW-1:LANE_W] == $past(cell_shift[DW-1:LANE_W]) + 1'b1));
endmodule

bind bst_engine bst_engine_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rti_state(rti_state), .runtest_on(runtest_on),
  .opcode(opcode), .en_ab(en_ab), .en_ba(en_ba), .a_pins(a_pins),
  .load_en(load_en), .load_cells(load_cells), .cell_shift(cell_shift)
);

// File: tb/sim_bst_engine.sv
module sim_bst_engine;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rti_state = 1'b0, runtest_on = 1'b0;
  logic [2:0]  opcode = 3'd0;
  logic        en_ab = 1'b0, en_ba = 1'b0;
  logic [19:0] a_pins = '0, b_pins = '0;
  logic [11:0] ctl_cells = '0;
  logic        load_en = 1'b0;
  logic [39:0] load_cells = '0;
  logic [39:0] cell_shift;
  logic [19:0] a_drive, b_drive;
  logic        a_oe, b_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [39:0] exp_cells = '0, exp_shadow = '0;
  bit          pend_lo = 0, pend_hi = 0;

  always #(CLK_P/2) clk = ~clk;

  bst_engine u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] model(input logic [39:0] cur, input logic [2:0] op,
                                        input bit ab, input logic [19:0] a,
                                        input logic [19:0] b);
    logic [19:0] ic, oc, ip, op_, ni, no;
    logic [39:0] c, d, n;
    bit fb;
    if (ab) begin ic = cur[19:0]; oc = cur[39:20]; ip = a; op_ = b; end
    else    begin ic = cur[39:20]; oc = cur[19:0]; ip = b; op_ = a; end
    c = {oc, ic}; d = {op_, ip};
    fb = c[39] ^ c[37] ^ c[20] ^ c[18];
    case (op[1:0])
      2'b00: n = {~oc, ip};
      2'b01: n = {c[38:0], fb};
      2'b10: n = {c[38:0], fb} ^ d;
      default: begin
        ni = {ic[18:0], ic[19] ^ ic[16]} ^ ip;
        if (op[2]) no = oc + 20'd1;
        else       no = {oc[18:0], oc[19] ^ oc[16]};
        n = {no, ni};
      end
    endcase
    return ab ? n : {n[19:0], n[39:20]};
  endfunction

  function automatic string req_of(input logic [2:0] op, input bit run, input bit eq);
    if (!run) return "R2";
    if (eq) return "R3";
    case (op[1:0])
      2'b00: return "R5/R11/R13";
      2'b01: return "R7/R11/R13";
      2'b10: return "R8/R11/R13";
      default: return op[2] ? "R10/R11" : "R9/R11";
    endcase
  endfunction

  // One full clock: shadow check after falling edge, then drive, then cell check.
  task automatic cyc(input bit ld, input logic [39:0] ldv, input logic [2:0] op,
                     input bit eab, input bit eba, input bit run,
                     input logic [19:0] a, input logic [19:0] b, input logic [11:0] ctl);
    bit act;
    @(negedge clk); #1;
    if (pend_lo) exp_shadow[19:0]  = exp_cells[19:0];
    if (pend_hi) exp_shadow[39:20] = exp_cells[39:20];
    chk({b_drive, a_drive} == exp_shadow, pend_lo | pend_hi ? "R4/R6" : "R6",
        {24'd0, b_drive, a_drive}, {24'd0, exp_shadow});
    load_en = ld; load_cells = ldv; opcode = op; en_ab = eab; en_ba = eba;
    rti_state = run; runtest_on = run; a_pins = a; b_pins = b; ctl_cells = ctl;
    #1;
    chk({a_oe, b_oe} == {ctl[10], ctl[11]}, "R12", {62'd0, a_oe, b_oe},
        {62'd0, ctl[10], ctl[11]});
    act = run && (eab != eba);
    pend_lo = ld || (!ld && act && op[1:0] == 2'b00 && eba);
    pend_hi = ld || (!ld && act && op[1:0] == 2'b00 && eab);
    @(posedge clk); #1;
    if (ld) begin
      exp_cells = ldv;
      chk(cell_shift == exp_cells, "R4", {24'd0, cell_shift}, {24'd0, exp_cells});
    end else begin
      if (act) exp_cells = model(exp_cells, op, eab, a, b);
      chk(cell_shift == exp_cells, req_of(op, run, eab == eba),
          {24'd0, cell_shift}, {24'd0, exp_cells});
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_P * 2 + 2);
    chk(cell_shift == '0 && a_drive == '0 && b_drive == '0, "R1",
        {24'd0, cell_shift}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // Count wrap, A input side.
    cyc(1, {20'hFFFFF, 20'h00001}, 3'b111, 1, 0, 0, '0, '0, 12'h400);
    cyc(0, '0, 3'b111, 1, 0, 1, 20'h12345, '0, 12'h400);
    chk(cell_shift[39:20] == 20'd0, "R10", {44'd0, cell_shift[39:20]}, 64'd0);
    // Count wrap, B input side.
    cyc(1, {20'h0, 20'hFFFFF}, 3'b111, 0, 1, 0, '0, '0, 12'h800);
    cyc(0, '0, 3'b111, 0, 1, 1, '0, 20'hABCDE, 12'h800);
    chk(cell_shift[19:0] == 20'd0, "R10", {44'd0, cell_shift[19:0]}, 64'd0);
    // Bypass with both enables on and both off.
    cyc(1, 40'hA5A5A_5A5A5, 3'b000, 1, 1, 1, '1, '1, 12'hC00);
    cyc(0, '0, 3'b000, 1, 1, 1, '1, '1, 12'hC00);
    cyc(0, '0, 3'b010, 0, 0, 1, '1, '1, 12'h000);
    // Idle controller.
    cyc(0, '0, 3'b001, 1, 0, 0, '1, '1, 12'h000);
    // Toggle both directions, then shadow stays with a non-toggle mode.
    cyc(0, '0, 3'b100, 1, 0, 1, 20'h0F0F0, 20'h33333, 12'h400);
    cyc(0, '0, 3'b000, 0, 1, 1, 20'h11111, 20'h22222, 12'h800);
    cyc(0, '0, 3'b011, 0, 1, 1, 20'h11111, 20'h22222, 12'h800);
    cyc(0, '0, 3'b011, 0, 1, 1, 20'h11111, 20'h22222, 12'h800);
    // Seed generators with a nonzero value and walk random traffic.
    cyc(1, 40'h80000_00001, 3'b001, 1, 0, 0, '0, '0, '0);
    for (int i = 0; i < 600; i++) begin
      logic [2:0] op = 3'($urandom);
      bit eab = 1'($urandom), eba;
      bit run = ($urandom % 8) != 0;
      bit ld = ($urandom % 40) == 0;
      eba = (($urandom % 6) == 0) ? eab : !eab;
      cyc(ld, {$urandom, $urandom}, op, eab, eba, run,
          20'($urandom), 20'($urandom), 12'($urandom));
    end
    cyc(0, '0, 3'b000, 0, 0, 0, '0, '0, '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule